// File: doc/BRIEF.md
# Filtered Event Counter with Threshold Qualification

The block is one general-purpose performance counter together with the control word that decides what it counts. Every clock cycle, surrounding logic supplies a small per-cycle count for each of a fixed set of event sources, a flag that says whether the processor is in kernel mode, and this counter's bit of the global enable. The control word picks one source by matching its 16-bit key (unit mask above event code) against a parameter table. It filters by privilege level. It can turn the per-cycle count into a one-per-cycle threshold hit, with optional inversion and edge detection. The result is added to a counter of parameterised width. A carry out of the counter gives a one-cycle overflow pulse and, when requested, a one-cycle interrupt request.

Software reaches both registers through a single-cycle register port. The port has one write strobe and one address bit, and the read data is combinational from that address. Event counts are sampled on every clock edge. They carry no valid or ready: the source cannot be stalled and there is no back-pressure, so a cycle that the block does not qualify is dropped and is not held. Counter writes take the low 32 bits of the write data, sign-extend them and keep the implemented width. The counter width must be greater than 32.

Top module: `pmc_event_counter`

## Requirements
- R1: A write with `reg_addr`=0 stores all 32 bits of the control word, and it reads back unchanged. Field layout: event code [7:0], unit mask [15:8], user enable 16, kernel enable 17, edge 18, pin control 19 (stored only), overflow interrupt 20, local enable 22, invert 23, count mask [31:24].
- R2: A write with `reg_addr`=1 loads the counter with `reg_wdata` sign-extended from bit 31 to the counter width. With the default 48 bits, writing 0xF3456789 reads back 0xFFFFF3456789.
- R3: The counter advances only in a cycle where both local enable (bit 22) and `glb_en` are 1.
- R4: With `priv_kernel`=1 the counter advances only if kernel enable (bit 17) is set. With `priv_kernel`=0 it advances only if user enable (bit 16) is set.
- R5: The source whose key equals {unit mask, event code} is selected. Default keys for sources 0..3 are 0x0011, 0x0122, 0x0033, 0x0244, and source i sits at `evt_counts[4i+3:4i]`. With count mask 0 the full per-cycle count is added. A key that matches no source adds nothing.
- R6: With a nonzero count mask and invert clear, the counter adds one in a cycle whose selected count is at least the mask, and zero otherwise.
- R7: With a nonzero count mask and invert set, the counter adds one in a cycle whose selected count is below the mask.
- R8: With edge set, the counter adds one only in a cycle where the threshold condition is true and was false in the previous cycle. With mask 0, the condition is "count nonzero".
- R9: The counter wraps through zero and keeps counting: preloaded to 1-N, it reads 1 after N events. `ovf_pulse` is high for exactly the one cycle after the wrapping edge.
- R10: `irq_req` pulses together with `ovf_pulse` only when overflow interrupt (bit 20) is set.
- R11: A counter write in the same cycle as an increment wins. Later increments continue from the written value.
- R12: After reset, both registers read 0 and `ovf_pulse` and `irq_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_counts | input | NUM_EVT*CNT_W | Per-cycle count of each event source |
| priv_kernel | input | 1 | 1 = kernel mode, 0 = user mode |
| glb_en | input | 1 | This counter's global enable bit |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control word, 1 = counter |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 64 | Read data of the addressed register, zero-extended |
| ovf_pulse | output | 1 | One-cycle pulse on counter wrap |
| irq_req | output | 1 | One-cycle interrupt request on wrap when enabled |

## Verification
Every vector holds a fixed mix of counts on the sources (1, 2, 3, 4). Each key therefore yields a distinct sum, which shows that the right source was picked. A threshold placed below, at and above the selected count of 3 separates the comparison direction and boundary, both with and without inversion. Privilege and enable vectors differ from a passing case in one bit only. Directed runs check held-high events under edge mode, a preload that wraps after two cycles, and a write that collides with a live increment.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  // Control word; bit positions are software-visible.
  typedef struct packed {
    logic [7:0] thresh;     // 31:24
    logic       invert;     // 23
    logic       local_en;   // 22
    logic       rsvd;       // 21
    logic       ovf_int;    // 20
    logic       pin_ctl;    // 19
    logic       edge_det;   // 18
    logic       kern_en;    // 17
    logic       user_en;    // 16
    logic [7:0] umask;      // 15:8
    logic [7:0] code;       // 7:0
  } ctl_word_t;

  localparam int KEY_W = 16;
  localparam int REG_W = 32;
endpackage

// File: rtl/pmc_evt_pick.sv
module pmc_evt_pick #(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 4,
  parameter logic [NUM_EVT*pmc_pkg::KEY_W-1:0] KEYS = '0
) (
  input  logic [NUM_EVT*CNT_W-1:0]  counts,
  input  logic [pmc_pkg::KEY_W-1:0] key,
  output logic [CNT_W-1:0]          picked
);
  localparam int KW = pmc_pkg::KEY_W;

  logic [NUM_EVT-1:0] hit;

  genvar g;
  generate
    for (g = 0; g < NUM_EVT; g++) begin : g_match
      assign hit[g] = (KEYS[g*KW +: KW] == key);
    end
  endgenerate

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (hit[i]) picked = picked | counts[i*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/pmc_thresh.sv
module pmc_thresh #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt,
  input  logic [7:0]       mask,
  input  logic             invert,
  input  logic             edge_det,
  output logic [CNT_W-1:0] inc
);
  localparam int CW = (CNT_W > 8) ? CNT_W : 8;

  logic [CW-1:0] cnt_x, mask_x;
  logic          mask_on, at_least, cond, prev_q;

  assign mask_on  = (mask != 8'd0);
  assign cnt_x    = CW'(cnt);
  assign mask_x   = mask_on ? CW'(mask) : CW'(1);
  assign at_least = (cnt_x >= mask_x);
  assign cond     = (invert && mask_on) ? !at_least : at_least;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= cond;
  end

  always_comb begin
    if (edge_det)     inc = CNT_W'(cond && !prev_q);
    else if (mask_on) inc = CNT_W'(cond);
    else              inc = cnt;
  end

  // R8: an edge-mode count never follows a cycle whose condition held
  p_edge_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_det && inc != '0) |-> !prev_q);
  // R6: threshold mode contributes at most one per cycle
  p_thresh_unit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_on && !edge_det) |-> (inc <= CNT_W'(1)));
endmodule

// File: rtl/pmc_accum.sv
module pmc_accum #(
  parameter int CTR_W = 48,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc_en,
  input  logic [CNT_W-1:0] inc,
  input  logic             wr,
  input  logic [31:0]      wdata,
  input  logic             ovf_int,
  output logic [CTR_W-1:0] ctr,
  output logic             ovf,
  output logic             irq
);
  localparam int EXT = CTR_W - 32;

  logic [CTR_W:0]   sum;
  logic [CTR_W-1:0] wval;
  logic             wrap;

  assign sum  = {1'b0, ctr} + (CTR_W+1)'(inc);
  assign wval = {{EXT{wdata[31]}}, wdata};
  assign wrap = inc_en && !wr && sum[CTR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr <= '0;
      ovf <= 1'b0;
      irq <= 1'b0;
    end else begin
      if (wr)          ctr <= wval;
      else if (inc_en) ctr <= sum[CTR_W-1:0];
      ovf <= wrap;
      irq <= wrap && ovf_int;
    end
  end

  // R11: software write takes precedence over a same-cycle increment
  p_write_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> (ctr == $past(wval)));
  // R9: right after a wrap the counter holds less than one increment
  p_wrap_small_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> (ctr < CTR_W'(2**CNT_W)));
  // R9: overflow is a single-cycle pulse
  p_ovf_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> !ovf);
endmodule

// File: rtl/pmc_event_counter.sv
module pmc_event_counter #(
  parameter int NUM_EVT = 4,
  parameter int CNT_W   = 4,
  parameter int CTR_W   = 48,
  parameter logic [NUM_EVT*pmc_pkg::KEY_W-1:0] KEYS =
    {16'h0244, 16'h0033, 16'h0122, 16'h0011}
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NUM_EVT*CNT_W-1:0] evt_counts,
  input  logic                     priv_kernel,
  input  logic                     glb_en,
  input  logic                     reg_wr,
  input  logic                     reg_addr,
  input  logic [31:0]              reg_wdata,
  output logic [63:0]              reg_rdata,
  output logic                     ovf_pulse,
  output logic                     irq_req
);
  import pmc_pkg::*;

  ctl_word_t        ctl_q;
  logic [CNT_W-1:0] picked, inc;
  logic [CTR_W-1:0] ctr;
  logic             priv_ok, count_ok, wr_ctr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    ctl_q <= '0;
    else if (reg_wr && !reg_addr)  ctl_q <= ctl_word_t'(reg_wdata);
  end

  assign wr_ctr   = reg_wr && reg_addr;
  assign priv_ok  = priv_kernel ? ctl_q.kern_en : ctl_q.user_en;
  assign count_ok = ctl_q.local_en && glb_en && priv_ok;

  pmc_evt_pick #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W), .KEYS(KEYS)) u_pick (
    .counts (evt_counts),
    .key    ({ctl_q.umask, ctl_q.code}),
    .picked (picked)
  );

  pmc_thresh #(.CNT_W(CNT_W)) u_thr (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt      (picked),
    .mask     (ctl_q.thresh),
    .invert   (ctl_q.invert),
    .edge_det (ctl_q.edge_det),
    .inc      (inc)
  );

  pmc_accum #(.CTR_W(CTR_W), .CNT_W(CNT_W)) u_acc (
    .clk     (clk),
    .rst_n   (rst_n),
    .inc_en  (count_ok),
    .inc     (inc),
    .wr      (wr_ctr),
    .wdata   (reg_wdata),
    .ovf_int (ctl_q.ovf_int),
    .ctr     (ctr),
    .ovf     (ovf_pulse),
    .irq     (irq_req)
  );

  assign reg_rdata = reg_addr ? 64'(ctr) : 64'(ctl_q);

  // R3/R4: an unqualified cycle without a write leaves the counter alone
  p_gated_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!count_ok && !wr_ctr) |=> $stable(ctr));
  // R10: interrupt request only accompanies an overflow
  p_irq_with_ovf_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> ovf_pulse);
endmodule

// File: tb/pmc_event_counter_test.sv
module pmc_event_counter_test;
  localparam logic [31:0] EN  = 32'h0040_0000;
  localparam logic [31:0] KS  = 32'h0002_0000;
  localparam logic [31:0] US  = 32'h0001_0000;
  localparam logic [31:0] INV = 32'h0080_0000;
  localparam logic [31:0] EDG = 32'h0004_0000;
  localparam logic [31:0] INT = 32'h0010_0000;
  localparam logic [15:0] EV  = 16'h4321; // src0=1 src1=2 src2=3 src3=4
  localparam int NV = 15;
  // {req, ctl, priv, glb, events, expected delta}
  localparam logic [61:0] VEC [NV] = '{
    {4'd5, EN|KS|US|32'h0011, 1'b1, 1'b1, EV, 8'd1},  // R5 src0
    {4'd5, EN|KS|US|32'h0122, 1'b1, 1'b1, EV, 8'd2},  // R5 src1
    {4'd5, EN|KS|US|32'h0244, 1'b1, 1'b1, EV, 8'd4},  // R5 src3
    {4'd5, EN|KS|US|32'h0099, 1'b1, 1'b1, EV, 8'd0},  // R5 no match
    {4'd4, EN|US|32'h0033,    1'b1, 1'b1, EV, 8'd0},  // R4 kernel filtered
    {4'd4, EN|US|32'h0033,    1'b0, 1'b1, EV, 8'd3},  // R4 user counted
    {4'd4, EN|KS|32'h0033,    1'b0, 1'b1, EV, 8'd0},  // R4 user filtered
    {4'd3, KS|US|32'h0033,    1'b1, 1'b1, EV, 8'd0},  // R3 local off
    {4'd3, EN|KS|US|32'h0033, 1'b1, 1'b0, EV, 8'd0},  // R3 global off
    {4'd6, 32'h0200_0000|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd1}, // R6 3>=2
    {4'd6, 32'h0400_0000|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd0}, // R6 3<4
    {4'd6, 32'h0300_0000|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd1}, // R6 equal
    {4'd7, 32'h0400_0000|INV|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd1}, // R7
    {4'd7, 32'h0300_0000|INV|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd0}, // R7
    {4'd8, 32'h0200_0000|EDG|EN|KS|US|32'h0033, 1'b1, 1'b1, EV, 8'd1}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] evt_counts = '0;
  logic        priv_kernel = 1'b1, glb_en = 1'b0;
  logic        reg_wr = 1'b0, reg_addr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [63:0] reg_rdata;
  logic        ovf_pulse, irq_req;
  int          n_chk = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  pmc_event_counter uut (
    .clk(clk), .rst_n(rst_n), .evt_counts(evt_counts),
    .priv_kernel(priv_kernel), .glb_en(glb_en), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .ovf_pulse(ovf_pulse), .irq_req(irq_req)
  );

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic a, logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 1'b1;
  endtask

  task automatic idle();
    evt_counts = '0; glb_en = 1'b0;
  endtask

  task automatic run(logic p, logic [15:0] ev);
    priv_kernel = p; glb_en = 1'b1; evt_counts = ev;
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    reg_addr = 1'b0; #1 chk("R12 ctl", reg_rdata, 64'h0);
    reg_addr = 1'b1; #1 chk("R12 ctr", reg_rdata, 64'h0);
    chk("R12 ovf", 64'(ovf_pulse), 64'h0);
    chk("R12 irq", 64'(irq_req), 64'h0);

    // Table walk
    for (int i = 0; i < NV; i++) begin
      wr(1'b0, VEC[i][57:26]);
      wr(1'b1, 32'h0);
      run(VEC[i][25], VEC[i][23:8]);
      glb_en = VEC[i][24];
      @(negedge clk);
      idle();
      #1 chk($sformatf("R%0d vec%0d", VEC[i][61:58], i), reg_rdata,
             64'(VEC[i][7:0]));
    end

    // R1 control word read-back
    wr(1'b0, 32'hA5C7_1234);
    reg_addr = 1'b0; #1 chk("R1 readback", reg_rdata, 64'hA5C7_1234);

    // R2 sign extension and truncation
    wr(1'b1, 32'hF345_6789);
    #1 chk("R2 negative", reg_rdata, 64'h0000_FFFF_F345_6789);
    wr(1'b1, 32'h7FFF_FFFF);
    #1 chk("R2 positive", reg_rdata, 64'h0000_0000_7FFF_FFFF);

    // R9 wrap: preload 1-6, count 3 per cycle for 2 cycles
    wr(1'b0, EN|KS|US|32'h0033);
    wr(1'b1, 32'hFFFF_FFFB);
    run(1'b1, EV);
    @(negedge clk);
    chk("R9 no early ovf", 64'(ovf_pulse), 64'h0);
    @(negedge clk);
    idle();
    #1 chk("R9 wrapped value", reg_rdata, 64'h1);
    chk("R9 ovf pulse", 64'(ovf_pulse), 64'h1);
    chk("R10 irq masked", 64'(irq_req), 64'h0);
    @(negedge clk);
    chk("R9 pulse ends", 64'(ovf_pulse), 64'h0);

    // R10 interrupt enabled
    wr(1'b0, INT|EN|KS|US|32'h0033);
    wr(1'b1, 32'hFFFF_FFFE);
    run(1'b1, EV);
    @(negedge clk);
    idle();
    chk("R10 irq", 64'(irq_req), 64'h1);
    chk("R10 ovf", 64'(ovf_pulse), 64'h1);

    // R11 write collides with increment, then counting resumes
    wr(1'b0, EN|KS|US|32'h0033);
    wr(1'b1, 32'h0);
    run(1'b1, EV);
    wr(1'b1, 32'd100);
    #1 chk("R11 write wins", reg_rdata, 64'd100);
    @(negedge clk);
    #1 chk("R11 continues", reg_rdata, 64'd103);
    idle();

    // R8 held event counts once per rising condition
    wr(1'b0, 32'h0200_0000|EDG|EN|KS|US|32'h0033);
    wr(1'b1, 32'h0);
    run(1'b1, EV);
    repeat (3) @(negedge clk);
    #1 chk("R8 held high", reg_rdata, 64'd1);
    evt_counts = '0;
    @(negedge clk);
    evt_counts = EV;
    @(negedge clk);
    idle();
    #1 chk("R8 second edge", reg_rdata, 64'd2);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule